// File: doc/BRIEF.md
# Readout Instruction Sequencer

A small programmable controller that steps through a list of 20-bit instruction words held in a local memory and turns them into front-end operations. Each word has a 4-bit opcode in bits [19:16] and a 16-bit operand in bits [15:0]. Some opcodes issue a command on a request/done port: status read, trigger-counter reads, channel readout, and pedestal-memory read and write. Other opcodes control the sequence itself: a cycle-counted wait, a stall until an L1 trigger, a counted or endless branch, and an end marker.

The program is written through a valid/ready load stream while the sequencer is idle. A `start` pulse runs the program from address 0, and `busy` stays high until an end marker or the `stop` input ends the run. A program whose last word branches back to its start runs until it is stopped. This supports register-probing loops and repeated readout.

Top module: `readout_seq`

## Requirements
- R1: Opcodes 4'h1, 4'h2, 4'h3, 4'h6, 4'h7 and 4'h8 each raise `cmd_valid` for exactly one cycle. In that cycle `cmd_op` carries the opcode and `cmd_arg` carries the full 16-bit operand unchanged, including the broadcast flag at operand bit 12.
- R2: After a command request, the sequencer waits for `cmd_done` and does not advance before it. The next instruction executes in the cycle after `cmd_done` is seen. A `cmd_done` that arrives while no command is pending has no effect.
- R3: A wait word (opcode 4'ha, operand N) delays the next instruction so that it executes N+1 cycles after the wait word. N=0 costs one cycle.
- R4: A trigger word (opcode 4'hb) stalls the program until `trig_l1` is high in a stall cycle. The next instruction executes in the following cycle.
- R5: A branch word (opcode 4'hc) uses operand [7:0] as the target address and operand [15:8] as a count K. When K is not zero, the branch is taken K times and execution then falls through to the next address.
- R6: A branch word with count 0 always branches, so the program runs until it is stopped.
- R7: An end word (opcode 4'h9) returns the sequencer to idle, and `busy` is low from the next cycle.
- R8: `stop` forces idle from the next cycle in any state. No `cmd_valid` is raised in a cycle where `stop` is high.
- R9: Any other opcode, such as 4'h0, is a no-op that advances to the next address in one cycle. The program counter wraps at 256.
- R10: The load stream writes `load_data` to address `load_addr` when both `load_valid` and `load_ready` are high. `load_ready` is high only while the sequencer is idle, so a word offered during a run waits there until the run ends.
- R11: A `start` pulse while idle begins execution at address 0, and `busy` is high from the next cycle. A `start` pulse during a run is ignored.
- R12: After reset the sequencer is idle: `busy` is low, `cmd_valid` is low and `load_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_valid | input | 1 | Instruction word offered on the load stream |
| load_ready | output | 1 | Load stream can accept a word (idle only) |
| load_addr | input | 8 | Memory address of the offered word |
| load_data | input | 20 | Instruction word, opcode in bits [19:16] |
| start | input | 1 | Run the program from address 0 |
| stop | input | 1 | Abort the run and go idle |
| trig_l1 | input | 1 | L1 trigger, used by the trigger stall |
| busy | output | 1 | A program is running |
| cmd_valid | output | 1 | One-cycle command request |
| cmd_op | output | 4 | Opcode of the requested command |
| cmd_arg | output | 16 | Operand of the requested command |
| cmd_done | input | 1 | Completion pulse for the pending command |

## Verification
A behavioural model tracks the state, program counter, wait count and loop count, and is compared with the outputs on every cycle. The first program issues every command opcode with a no-op and a broadcast pedestal access mixed in, and uses a long done latency. This shows both the command encoding and the hold until done. Wait programs with N=5 and N=0 separate the N+1 timing from an off-by-one error. A trigger program with a stray done during the stall confirms that only `trig_l1` releases the stall. Counted (K=3) and endless branches separate a fall-through after K repeats from K±1 repeats and from looping forever, and the endless run is also hit with start and load attempts during the run and then with `stop`.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int OPW  = 4;
  localparam int ARGW = 16;
  localparam int IW   = OPW + ARGW;

  localparam logic [OPW-1:0] OP_STAT  = 4'h1;
  localparam logic [OPW-1:0] OP_L1CNT = 4'h2;
  localparam logic [OPW-1:0] OP_L2CNT = 4'h3;
  localparam logic [OPW-1:0] OP_CHRD  = 4'h6;
  localparam logic [OPW-1:0] OP_PMRD  = 4'h7;
  localparam logic [OPW-1:0] OP_PMWR  = 4'h8;
  localparam logic [OPW-1:0] OP_END   = 4'h9;
  localparam logic [OPW-1:0] OP_WAIT  = 4'ha;
  localparam logic [OPW-1:0] OP_TRIG  = 4'hb;
  localparam logic [OPW-1:0] OP_JUMP  = 4'hc;

  typedef enum logic [2:0] {
    S_IDLE, S_EXEC, S_BUS, S_DELAY, S_TRIG
  } seq_state_t;

  function automatic logic is_bus_op(input logic [OPW-1:0] op);
    return (op == OP_STAT) || (op == OP_L1CNT) || (op == OP_L2CNT) ||
           (op == OP_CHRD) || (op == OP_PMRD)  || (op == OP_PMWR);
  endfunction
endpackage

// File: rtl/seq_imem.sv
module seq_imem #(
  parameter int AW = 8,
  parameter int DW = 20
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/seq_loop_unit.sv
module seq_loop_unit #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          take,
  input  logic [CW-1:0] count,
  output logic          branch
);
  logic          act;
  logic [CW-1:0] rem;

  assign branch = (count == '0) || !act || (rem != '0);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      act <= 1'b0;
      rem <= '0;
    end else if (take && count != '0) begin
      if (!act) begin
        act <= 1'b1;
        rem <= count - 1'b1;
      end else if (rem == '0) begin
        act <= 1'b0;
      end else begin
        rem <= rem - 1'b1;
      end
    end
  end
endmodule

// File: rtl/seq_delay.sv
module seq_delay #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         expire
);
  logic [W-1:0] cnt;

  assign expire = (cnt == W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr)   cnt <= '0;
    else if (load)       cnt <= len;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/readout_seq.sv
module readout_seq
  import seq_pkg::*;
#(
  parameter int PC_W  = 8,
  parameter int CNT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_valid,
  output logic                load_ready,
  input  logic [PC_W-1:0]     load_addr,
  input  logic [IW-1:0]       load_data,
  input  logic                start,
  input  logic                stop,
  input  logic                trig_l1,
  output logic                busy,
  output logic                cmd_valid,
  output logic [OPW-1:0]      cmd_op,
  output logic [ARGW-1:0]     cmd_arg,
  input  logic                cmd_done
);
  localparam int CNT_LSB = ARGW - CNT_W;

  seq_state_t      st;
  logic [PC_W-1:0] pc;
  logic [IW-1:0]   word;
  logic [OPW-1:0]  op;
  logic [ARGW-1:0] arg;
  logic            exec_ok, branch, expire;

  assign op      = word[IW-1 -: OPW];
  assign arg     = word[ARGW-1:0];
  assign exec_ok = (st == S_EXEC) && !stop;

  seq_imem #(.AW(PC_W), .DW(IW)) u_imem (
    .clk(clk), .we(load_valid && load_ready), .waddr(load_addr),
    .wdata(load_data), .raddr(pc), .rdata(word)
  );

  seq_loop_unit #(.CW(CNT_W)) u_loop (
    .clk(clk), .rst_n(rst_n), .clr(stop || st == S_IDLE),
    .take(exec_ok && op == OP_JUMP), .count(arg[ARGW-1:CNT_LSB]),
    .branch(branch)
  );

  seq_delay #(.W(ARGW)) u_delay (
    .clk(clk), .rst_n(rst_n), .clr(stop),
    .load(exec_ok && op == OP_WAIT), .len(arg), .expire(expire)
  );

  assign busy       = (st != S_IDLE);
  assign load_ready = (st == S_IDLE);
  assign cmd_valid  = exec_ok && is_bus_op(op);
  assign cmd_op     = op;
  assign cmd_arg    = arg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      pc <= '0;
    end else if (stop) begin
      st <= S_IDLE;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          st <= S_EXEC;
          pc <= '0;
        end
        S_EXEC: begin
          if (is_bus_op(op))        st <= S_BUS;
          else if (op == OP_END)    st <= S_IDLE;
          else if (op == OP_WAIT) begin
            if (arg == '0) pc <= pc + 1'b1;
            else           st <= S_DELAY;
          end
          else if (op == OP_TRIG)   st <= S_TRIG;
          else if (op == OP_JUMP)   pc <= branch ? arg[PC_W-1:0] : pc + 1'b1;
          else                      pc <= pc + 1'b1;
        end
        S_BUS: if (cmd_done) begin
          pc <= pc + 1'b1;
          st <= S_EXEC;
        end
        S_DELAY: if (expire) begin
          pc <= pc + 1'b1;
          st <= S_EXEC;
        end
        S_TRIG: if (trig_l1) begin
          pc <= pc + 1'b1;
          st <= S_EXEC;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/readout_seq_chk.sv
module readout_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic stop,
  input logic busy,
  input logic cmd_valid,
  input logic load_valid,
  input logic load_ready
);
  a_r1_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  a_r1_req_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> busy);
  a_r8_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !busy);
  a_r8_no_req_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop |-> !cmd_valid);
  a_r11_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !stop) |=> busy);
  a_r10_load_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && load_ready) |-> !busy);
endmodule

bind readout_seq readout_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .busy(busy),
  .cmd_valid(cmd_valid), .load_valid(load_valid), .load_ready(load_ready)
);

// File: tb/test_readout_seq.sv
module test_readout_seq;
  logic        clk = 0, rst_n = 0;
  logic        load_valid = 0, start = 0, stop = 0, trig_l1 = 0;
  logic [7:0]  load_addr = 0;
  logic [19:0] load_data = 0;
  logic        load_ready, busy, cmd_valid, cmd_done;
  logic [3:0]  cmd_op;
  logic [15:0] cmd_arg;
  logic        resp_done = 0, stray_done = 0;

  int errors = 0, checks = 0, cyc = 0, resp_cnt = 0, resp_lat = 1;
  string cur_req = "R12";
  int log_op[$], log_arg[$], log_cyc[$];
  bit finished = 0;

  assign cmd_done = resp_done | stray_done;

  readout_seq i_readout_seq (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_ready(load_ready),
    .load_addr(load_addr), .load_data(load_data), .start(start), .stop(stop),
    .trig_l1(trig_l1), .busy(busy), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_arg(cmd_arg), .cmd_done(cmd_done)
  );

  always #10 clk = ~clk;

  // reference model: 0 idle, 1 exec, 2 bus, 3 delay, 4 trig
  logic [19:0] m_mem [256];
  int ms = 0, mpc = 0, mcnt = 0, mrem = 0;
  bit mact = 0;

  function automatic bit bus_op(int op);
    return op == 1 || op == 2 || op == 3 || op == 6 || op == 7 || op == 8;
  endfunction

  function automatic int cur_op();
    return int'(m_mem[mpc][19:16]);
  endfunction

  function automatic int cur_arg();
    return int'(m_mem[mpc][15:0]);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      ms = 0; mpc = 0; mcnt = 0; mact = 0; mrem = 0;
    end else begin
      if (load_valid && ms == 0) m_mem[load_addr] = load_data;
      if (stop) begin
        ms = 0; mcnt = 0; mact = 0;
      end else begin
        case (ms)
          0: begin mact = 0; if (start) begin ms = 1; mpc = 0; end end
          1: begin
            int op, arg, k;
            op = cur_op(); arg = cur_arg(); k = arg >> 8;
            if (bus_op(op)) ms = 2;
            else if (op == 9) ms = 0;
            else if (op == 10) begin
              if (arg == 0) mpc = (mpc + 1) % 256;
              else begin ms = 3; mcnt = arg; end
            end
            else if (op == 11) ms = 4;
            else if (op == 12) begin
              if (k == 0) mpc = arg & 255;
              else if (!mact) begin mact = 1; mrem = k - 1; mpc = arg & 255; end
              else if (mrem == 0) begin mact = 0; mpc = (mpc + 1) % 256; end
              else begin mrem--; mpc = arg & 255; end
            end
            else mpc = (mpc + 1) % 256;
          end
          2: if (cmd_done) begin ms = 1; mpc = (mpc + 1) % 256; end
          3: begin
            if (mcnt == 1) begin ms = 1; mpc = (mpc + 1) % 256; end
            if (mcnt != 0) mcnt--;
          end
          4: if (trig_l1) begin ms = 1; mpc = (mpc + 1) % 256; end
          default: ms = 0;
        endcase
      end
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-cycle compare and command responder
  always begin
    @(negedge clk);
    if (resp_cnt > 0) begin
      resp_cnt--;
      resp_done = (resp_cnt == 0);
    end else resp_done = 0;
    #5;
    if (rst_n) begin
      bit mv;
      mv = (ms == 1) && bus_op(cur_op()) && !stop;
      check(busy === (ms != 0), cur_req, "busy", int'(busy), int'(ms != 0));
      check(load_ready === (ms == 0), cur_req, "load_ready", int'(load_ready), int'(ms == 0));
      check(cmd_valid === mv, cur_req, "cmd_valid", int'(cmd_valid), int'(mv));
      if (mv) begin
        check(cmd_op === cur_op(), cur_req, "cmd_op", int'(cmd_op), cur_op());
        check(cmd_arg === cur_arg(), cur_req, "cmd_arg", int'(cmd_arg), cur_arg());
      end
      if (cmd_valid) begin
        log_op.push_back(int'(cmd_op));
        log_arg.push_back(int'(cmd_arg));
        log_cyc.push_back(cyc);
        resp_cnt = resp_lat;
      end
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_word(int addr, logic [19:0] data);
    @(negedge clk);
    load_valid = 1; load_addr = 8'(addr); load_data = data;
    @(negedge clk);
    load_valid = 0;
  endtask

  task automatic run_prog();
    log_op.delete(); log_arg.delete(); log_cyc.delete();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_idle(int limit);
    for (int i = 0; i < limit && busy; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    cycles(3);
    rst_n = 1;
    #6;
    // R12 reset state
    check(busy === 0 && cmd_valid === 0 && load_ready === 1, "R12", "reset outputs",
          int'({busy, cmd_valid, load_ready}), 1);

    // P1: every command opcode, no-op, end; long latency (R1 R2 R9 R7)
    cur_req = "R1";
    load_word(0, 20'h1_1234);
    load_word(1, 20'h0_5555);
    load_word(2, 20'h7_1005);
    load_word(3, 20'h8_0042);
    load_word(4, 20'h2_0000);
    load_word(5, 20'h3_0001);
    load_word(6, 20'h6_00ff);
    load_word(7, 20'h9_0000);
    resp_lat = 4;
    run_prog();
    wait_idle(200);
    cycles(2);
    check(log_op.size() == 6, "R1", "command count", log_op.size(), 6);
    if (log_op.size() == 6) begin
      check(log_op[1] == 7 && log_arg[1] == 'h1005, "R1", "broadcast pedestal read arg",
            log_arg[1], 'h1005);
      check(log_op[5] == 6, "R1", "channel readout opcode", log_op[5], 6);
      check(log_cyc[2] - log_cyc[1] == 5, "R2", "gap with done latency 4",
            log_cyc[2] - log_cyc[1], 5);
      check(log_cyc[1] - log_cyc[0] == 6, "R9", "no-op costs one cycle",
            log_cyc[1] - log_cyc[0], 6);
    end
    check(busy === 0, "R7", "idle after end", int'(busy), 0);

    // P2: waits N=5 and N=0 (R3)
    cur_req = "R3";
    resp_lat = 1;
    load_word(0, 20'h1_0000);
    load_word(1, 20'ha_0005);
    load_word(2, 20'h2_0000);
    load_word(3, 20'ha_0000);
    load_word(4, 20'h3_0000);
    load_word(5, 20'h9_0000);
    run_prog();
    wait_idle(200);
    check(log_cyc.size() == 3, "R3", "command count", log_cyc.size(), 3);
    if (log_cyc.size() == 3) begin
      check(log_cyc[1] - log_cyc[0] == 8, "R3", "wait 5 gap", log_cyc[1] - log_cyc[0], 8);
      check(log_cyc[2] - log_cyc[1] == 3, "R3", "wait 0 gap", log_cyc[2] - log_cyc[1], 3);
    end

    // P3: trigger stall with stray done (R4 R2)
    cur_req = "R4";
    load_word(0, 20'hb_0000);
    load_word(1, 20'h6_0abc);
    load_word(2, 20'h9_0000);
    run_prog();
    cycles(5);
    stray_done = 1;
    cycles(1);
    stray_done = 0;
    cycles(5);
    check(log_op.size() == 0 && busy === 1, "R4", "stalled without trigger",
          log_op.size(), 0);
    trig_l1 = 1;
    cycles(1);
    trig_l1 = 0;
    wait_idle(50);
    check(log_op.size() == 1, "R4", "readout after trigger", log_op.size(), 1);
    if (log_op.size() == 1)
      check(log_arg[0] == 'h0abc, "R2", "stray done did not skip", log_arg[0], 'h0abc);

    // P4: counted loop K=3 (R5)
    cur_req = "R5";
    load_word(0, 20'h1_aaaa);
    load_word(1, 20'hc_0300);
    load_word(2, 20'h2_0000);
    load_word(3, 20'h9_0000);
    run_prog();
    wait_idle(300);
    check(log_op.size() == 5, "R5", "commands in K=3 loop", log_op.size(), 5);
    if (log_op.size() == 5)
      check(log_op[4] == 2 && log_op[3] == 1, "R5", "fall-through after loop", log_op[4], 2);

    // P5: endless loop, start/load during run, stop (R6 R11 R10 R8)
    cur_req = "R6";
    load_word(0, 20'h1_0777);
    load_word(1, 20'hc_0000);
    run_prog();
    cycles(20);
    cur_req = "R11";
    start = 1; cycles(1); start = 0;
    cur_req = "R10";
    load_valid = 1; load_addr = 0; load_data = 20'h9_0000;
    cycles(1);
    check(load_ready === 0, "R10", "no load accepted while running", int'(load_ready), 0);
    cycles(40);
    load_valid = 0;
    check(busy === 1, "R6", "still running", int'(busy), 1);
    check(log_op.size() >= 15, "R6", "repeated requests", log_op.size(), 15);
    cur_req = "R8";
    stop = 1;
    cycles(1);
    stop = 0;
    #6;
    check(busy === 0 && cmd_valid === 0, "R8", "idle after stop", int'(busy), 0);
    cycles(10);
    finish_run();
  end
endmodule